// File: doc/BRIEF.md
# Byte-Register Target on a Two-Wire Serial Bus

This block is a target on an I2C bus. It answers a 7-bit address set on an input port, and it fronts a file of 64 byte-wide registers. It oversamples the bus lines with the system clock and recognises Start, repeated Start and Stop conditions. It shifts in each address or data byte and pulls SDA low through an open-drain enable to acknowledge it on the ninth clock.

A write transfer carries a command byte, which sets an internal register pointer. Any data bytes that follow are stored at the pointer, and the pointer steps up by one after each byte. To read, the controller writes the command byte and then issues a repeated Start with the read bit set. The target then returns the register at the pointer. It keeps advancing while the controller acknowledges, and it lets go of the line after a not-acknowledge.

A Stop always returns the pointer to zero. A local port lets on-chip logic write any register and read any register directly.

Top module: `i2c_regfile_target`

## Requirements
- R1: After a Start, when the first eight bits (MSB first) carry `dev_addr` followed by a direction bit, the target holds `sda_oe` high for the whole high phase of the ninth SCL pulse.
- R2: When the address bits differ from `dev_addr`, the target gives no acknowledge and keeps `sda_oe` low for all later bytes until the next Start, and those bytes change no register.
- R3: In a write transfer (direction bit 0), the byte after the address sets the register pointer from its lower six bits only; bits 7 and 6 are ignored. The target acknowledges this byte.
- R4: Each further byte of a write transfer is acknowledged, stored in the register at the pointer, and followed by a pointer increment of one.
- R5: The pointer wraps from 63 to 0 on increment, in both writes and reads.
- R6: After a repeated Start with the same address and direction bit 1, the target sends the register at the pointer MSB first by driving `sda_oe` high for every 0 bit.
- R7: When the controller acknowledges a sent byte (SDA low on the ninth clock), the target sends the next register. On a not-acknowledge, it keeps `sda_oe` low until a Start or Stop.
- R8: A Stop resets the register pointer to 0, so a read that follows directly with no command byte returns register 0.
- R9: `sda_oe` changes only while the synchronised SCL is low.
- R10: Raising `host_we` writes `host_wdata` into register `host_addr` at the next clock edge. `host_rdata` always shows the register selected by `host_addr`.
- R11: After reset, `sda_oe` is low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Bus address the target answers |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| host_addr | input | 6 | Local register select |
| host_we | input | 1 | Local write strobe |
| host_wdata | input | 8 | Local write data |
| host_rdata | output | 8 | Register at `host_addr` |

## Verification
The bench drives the bus bit by bit and compares `sda_oe` against a behavioural model on every clock of each SCL-high phase. A write that uses a command byte with its top bits set tells real masking apart from a full-byte pointer load. Writes and reads that start at register 63 show whether the pointer wraps. A read with no command after a Stop shows whether Stop resets the pointer, and a run with a foreign address shows whether stray bytes are ignored. Reads that end with acknowledge and with not-acknowledge separate continued sending from release, and a local-port write read back over the bus ties the two access paths together.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       dev_addr,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [PTR_W-1:0] host_addr,
  input  logic             host_we,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata
);
  localparam int DEPTH = 1 << PTR_W;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WR, S_ACK, S_TX, S_MACK} st_t;

  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  st_t st, after_ack;
  logic [3:0] cnt;
  logic [7:0] sr, txsr;
  logic [PTR_W-1:0] ptr;
  logic mack;
  logic [7:0] regs [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_q, scl_s, scl_m, sda_q, sda_s, sda_m} <= '1;
    else        {scl_q, scl_s, scl_m, sda_q, sda_s, sda_m} <= {scl_s, scl_m, scl_i, sda_s, sda_m, sda_i};

  wire start_c   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  wire rise      = scl_s & ~scl_q;
  wire fall      = ~scl_s & scl_q;
  wire byte_done = fall && (cnt == 4'd8);
  wire addr_hit  = (sr[7:1] == dev_addr);
  wire wr_fire   = (st == S_WR) && byte_done;
  wire [7:0] cur_byte = regs[ptr];
  wire [7:0] nxt_byte = regs[ptr + 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; after_ack <= S_IDLE; cnt <= '0; sr <= '0; txsr <= '0;
      ptr <= '0; mack <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; ptr <= '0; sda_oe <= 1'b0; cnt <= '0;
    end else if (start_c) begin
      st <= S_ADDR; sda_oe <= 1'b0; cnt <= '0;
    end else begin
      case (st)
        S_ADDR, S_CMD, S_WR: begin
          if (rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            if (st == S_ADDR && !addr_hit) begin
              st <= S_IDLE;
            end else begin
              st     <= S_ACK;
              sda_oe <= 1'b1;
              if (st == S_ADDR) after_ack <= sr[0] ? S_TX : S_CMD;
              else              after_ack <= S_WR;
            end
            if (st == S_CMD) ptr <= sr[PTR_W-1:0];
            if (wr_fire)     ptr <= ptr + 1'b1;
          end
        end
        S_ACK: if (fall) begin
          if (after_ack == S_TX) begin
            st <= S_TX; txsr <= cur_byte; sda_oe <= ~cur_byte[7]; cnt <= '0;
          end else begin
            st <= after_ack; sda_oe <= 1'b0;
          end
        end
        S_TX: if (fall) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            sda_oe <= 1'b0; st <= S_MACK;
          end else begin
            sda_oe <= ~txsr[6]; txsr <= {txsr[6:0], 1'b0};
          end
        end
        S_MACK: begin
          if (rise) mack <= ~sda_s;
          else if (fall) begin
            if (mack) begin
              ptr <= ptr + 1'b1; st <= S_TX; txsr <= nxt_byte;
              sda_oe <= ~nxt_byte[7]; cnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[ptr] <= sr;
    end else if (host_we) begin
      regs[host_addr] <= host_wdata;
    end
  end

  assign host_rdata = regs[host_addr];

  AST_ACK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK) |-> sda_oe);  // R1
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);  // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ptr == '1) |=> (ptr == '0));  // R5
  AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK) |-> !sda_oe);  // R7
  AST_STOP_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (ptr == '0));  // R8
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);  // R9
endmodule

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb_top;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h4A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [5:0] host_addr = '0;
  logic host_we = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  logic [7:0] mdl [64];
  int ptr_m = 0;
  logic model_on = 1'b0, exp_oe = 1'b0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  i2c_regfile_target dut_i (
    .clk(clk), .rst_n(rst_n), .dev_addr(ADDR), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (model_on) chk(sda_oe === exp_oe, cur_req, sda_oe, exp_oe);

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq(); scl = 1'b1; waitq(); sda_m = 1'b0; waitq(); scl = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq(); scl = 1'b1; waitq(); sda_m = 1'b1; waitq();
    ptr_m = 0;
  endtask

  task automatic bit_cycle(input logic mbit, input logic eoe, input string req, output logic bus);
    sda_m = mbit; waitq();
    scl = 1'b1; exp_oe = eoe; cur_req = req; model_on = 1'b1;
    waitq(); waitq();
    bus = sda_bus; model_on = 1'b0;
    scl = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack, input string req);
    logic bus;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, "R9", bus);
    bit_cycle(1'b1, ack, req, bus);
    chk(bus == ~ack, req, bus, ~ack);
  endtask

  task automatic recv_byte(input logic mack, input string req);
    logic [7:0] got, exp;
    logic bus;
    exp = mdl[ptr_m];
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, ~exp[i], req, bus);
      got[i] = bus;
    end
    chk(got == exp, req, got, exp);
    bit_cycle(~mack, 1'b0, "R7", bus);
    if (mack) ptr_m = (ptr_m + 1) % 64;
  endtask

  task automatic write_regs(input logic [7:0] cmd, input logic [7:0] data[$]);
    i2c_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R1");
    send_byte(cmd, 1'b1, "R3");
    ptr_m = cmd & 8'h3F;
    foreach (data[k]) begin
      send_byte(data[k], 1'b1, "R4");
      mdl[ptr_m] = data[k];
      ptr_m = (ptr_m + 1) % 64;
    end
    i2c_stop();
  endtask

  task automatic read_regs(input logic [7:0] cmd, input int n, input string req);
    i2c_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R1");
    send_byte(cmd, 1'b1, "R3");
    ptr_m = cmd & 8'h3F;
    i2c_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R6");
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, req);
    i2c_stop();
  endtask

  task automatic host_check(input logic [5:0] a, input string req);
    host_addr = a;
    @(negedge clk);
    chk(host_rdata == mdl[a], req, host_rdata, mdl[a]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);
    host_check(6'd0, "R11");
    host_check(6'd63, "R11");

    write_regs(8'hC5, '{8'hA1, 8'hB2, 8'h3C});
    host_check(6'd5, "R3");
    host_check(6'd6, "R4");
    host_check(6'd7, "R4");

    read_regs(8'h05, 3, "R6");
    read_regs(8'h06, 1, "R7");

    write_regs(8'h3F, '{8'h11, 8'h22});
    host_check(6'd63, "R5");
    host_check(6'd0, "R5");
    read_regs(8'h3F, 2, "R5");

    i2c_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R1");
    send_byte(8'h0A, 1'b1, "R3");
    i2c_stop();
    i2c_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R8");
    recv_byte(1'b1, "R8");
    recv_byte(1'b0, "R8");
    i2c_stop();

    i2c_start();
    send_byte({7'h23, 1'b0}, 1'b0, "R2");
    send_byte(8'h03, 1'b0, "R2");
    send_byte(8'h77, 1'b0, "R2");
    i2c_stop();
    host_check(6'd3, "R2");
    host_check(6'd5, "R2");

    host_addr = 6'd20; host_wdata = 8'h5A; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    mdl[20] = 8'h5A;
    host_check(6'd20, "R10");
    read_regs(8'h14, 1, "R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule